// File: doc/BRIEF.md
# Packet Readout Controller

This block sits between a storage FIFO of packet words and the logic that consumes them. Each FIFO entry is a 128-bit word with four flag fields: a start marker, an end marker, an error marker and a 4-bit tail byte count. The controller only pops entries while it is serving a read request. It passes accepted words straight through to its output in the same cycle. It tracks how many bytes it has delivered, with byte resolution.

A request runs in one of two modes. In packet mode the controller reads exactly one packet and stops after that packet's end word. In budget mode it reads whole packets until the bytes delivered reach or exceed a requested budget. It then reports the signed difference, budget minus delivered, which a deficit-style scheduler carries into its next round. Packets flagged as errored are popped and discarded, and each one is counted. Stray words outside any packet are also discarded.

A packet is assumed to be shorter than 2^BUDGET_W bytes.

Top module: `prd_readout`

## Requirements
- R1: `req_ready` is high exactly when no request is active. A request is accepted on a cycle with `req_valid` and `req_ready` both high. `req_mode` is 0 for packet mode and 1 for budget mode.
- R2: `in_ready` is low whenever no request is active. An entry is popped on a cycle with `in_valid` and `in_ready` both high.
- R3: A delivered word appears on `out_data` with `out_valid` high in the cycle it is popped. `out_first` is high for a packet's first word and `out_last` is high for its end word.
- R4: `out_bytes` is 16 for every word that is not an end word. For an end word it equals the tail count field, where the value 0 stands for 16.
- R5: A packet whose first word carries the error marker has every one of its words popped and none presented. `drop_count` rises by one when its end word is popped.
- R6: A word without the start marker that arrives while no packet is open is popped and discarded, and it is not counted.
- R7: In packet mode the request ends when the first end word of a packet is popped, whether that packet was delivered or dropped. `done` is high in the following cycle.
- R8: In budget mode, at every packet boundary (including the start of the request), the controller stops popping once the delivered bytes are at least the budget. One cycle later `done` rises, and `deficit` becomes budget minus delivered bytes as a BUDGET_W+2 bit two's-complement value. Dropped packets add no bytes. A budget of 0 ends the request without a pop.
- R9: `done` is a single-cycle pulse for each request.
- R10: After reset `req_ready` is 1, while `in_ready`, `out_valid`, `done`, `deficit` and `drop_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_mode | input | 1 | 0 packet mode, 1 budget mode |
| req_budget | input | BUDGET_W | Byte budget for budget mode |
| in_valid | input | 1 | FIFO entry available |
| in_ready | output | 1 | Pop strobe qualifier |
| in_data | input | DATA_W | Stored word |
| in_sop | input | 1 | Start-of-packet marker |
| in_eop | input | 1 | End-of-packet marker |
| in_err | input | 1 | Error marker |
| in_size | input | SIZE_W | Valid bytes in end word, 0 means 16 |
| out_valid | output | 1 | Delivered word present |
| out_data | output | DATA_W | Delivered word |
| out_first | output | 1 | First word of a packet |
| out_last | output | 1 | End word of a packet |
| out_bytes | output | SIZE_W+1 | Valid bytes in delivered word |
| done | output | 1 | Request finished pulse |
| deficit | output | BUDGET_W+2 | Budget minus delivered bytes, signed |
| drop_count | output | DROP_W | Count of dropped errored packets |

## Verification
On every cycle, the bound assertions check several things. Nothing is popped while idle. Every output word matches a pop. Non-final words carry 16 bytes and final words carry 1 to 16. Errored first words and stray words never reach the output. The drop counter steps by one at most, and `done` is a lone pulse that coincides with every return to idle. The bench's cycle-accurate reference model is what shows the outcomes that depend on history. These are: where a budget request stops and the exact deficit it reports, a packet mode request that ends on a dropped packet, a zero budget, and an error marker on a middle word being ignored.

// File: rtl/prd_pkg.sv
package prd_pkg;

   typedef enum logic {
      MODE_PACKET = 1'b0,
      MODE_BUDGET = 1'b1
   } rd_mode_e;

endpackage

// File: rtl/prd_word_len.sv
// Valid byte count of one popped word: full width unless it closes a packet.
module prd_word_len #(
   parameter int SIZE_W = 4,
   parameter int CNT_W  = SIZE_W + 1
) (
   input  logic              is_last,
   input  logic [SIZE_W-1:0] tail_size,
   output logic [CNT_W-1:0]  nbytes
);
   localparam int FULL_BYTES = 1 << SIZE_W;

   always_comb begin
      if (!is_last || tail_size == '0)
         nbytes = CNT_W'(FULL_BYTES);
      else
         nbytes = CNT_W'(tail_size);
   end
endmodule

// File: rtl/prd_drop_ctr.sv
// Dropped-packet counter; SATURATE picks a sticky or a wrapping variant.
module prd_drop_ctr #(
   parameter int W        = 8,
   parameter bit SATURATE = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bump,
   output logic [W-1:0] count
);
   generate
      if (SATURATE) begin : g_sat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               count <= '0;
            else if (bump && count != '1)
               count <= count + W'(1);
         end
      end else begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               count <= '0;
            else if (bump)
               count <= count + W'(1);
         end
      end
   endgenerate
endmodule

// File: rtl/prd_req_ctl.sv
// Request sequencer: owns busy state, mode, byte accumulation and stop rule.
module prd_req_ctl
   import prd_pkg::*;
#(
   parameter int BUDGET_W = 16,
   parameter int CNT_W    = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  rd_mode_e            req_mode,
   input  logic [BUDGET_W-1:0] req_budget,
   input  logic                pkt_open,
   input  logic                deliver,
   input  logic [CNT_W-1:0]    nbytes,
   input  logic                eop_end,
   output logic                req_ready,
   output logic                in_gate,
   output logic                done,
   output logic [BUDGET_W+1:0] deficit
);
   localparam int ACC_W = BUDGET_W + 1;
   localparam int DEF_W = BUDGET_W + 2;

   logic                busy_q;
   rd_mode_e            mode_q;
   logic [BUDGET_W-1:0] budget_q;
   logic [ACC_W-1:0]    acc_q;
   logic                stop;
   logic [DEF_W-1:0]    diff;

   assign stop      = busy_q && (mode_q == MODE_BUDGET) && !pkt_open &&
                      (acc_q >= {1'b0, budget_q});
   assign in_gate   = busy_q && !stop;
   assign req_ready = !busy_q;
   assign diff      = {2'b00, budget_q} - {1'b0, acc_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         mode_q   <= MODE_PACKET;
         budget_q <= '0;
         acc_q    <= '0;
         done     <= 1'b0;
         deficit  <= '0;
      end else begin
         done <= 1'b0;
         if (!busy_q) begin
            if (req_valid) begin
               busy_q   <= 1'b1;
               mode_q   <= req_mode;
               budget_q <= req_budget;
               acc_q    <= '0;
            end
         end else if (stop) begin
            busy_q  <= 1'b0;
            done    <= 1'b1;
            deficit <= diff;
         end else begin
            if (deliver)
               acc_q <= acc_q + ACC_W'(nbytes);
            if (eop_end && mode_q == MODE_PACKET) begin
               busy_q <= 1'b0;
               done   <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/prd_readout.sv
// Packet readout controller: pops flagged words, frames packets, drops errored ones.
module prd_readout
   import prd_pkg::*;
#(
   parameter int DATA_W   = 128,
   parameter int SIZE_W   = 4,
   parameter int BUDGET_W = 16,
   parameter int DROP_W   = 8,
   parameter bit DROP_SAT = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic                req_mode,
   input  logic [BUDGET_W-1:0] req_budget,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [DATA_W-1:0]   in_data,
   input  logic                in_sop,
   input  logic                in_eop,
   input  logic                in_err,
   input  logic [SIZE_W-1:0]   in_size,
   output logic                out_valid,
   output logic [DATA_W-1:0]   out_data,
   output logic                out_first,
   output logic                out_last,
   output logic [SIZE_W:0]     out_bytes,
   output logic                done,
   output logic [BUDGET_W+1:0] deficit,
   output logic [DROP_W-1:0]   drop_count
);
   localparam int CNT_W = SIZE_W + 1;

   generate
      if (DATA_W != 8 * (1 << SIZE_W)) begin : g_bad_width
         $error("DATA_W must hold exactly 2**SIZE_W bytes");
      end
      if (BUDGET_W < 2) begin : g_bad_budget
         $error("BUDGET_W must be at least 2");
      end
      if (DROP_W < 1) begin : g_bad_drop
         $error("DROP_W must be at least 1");
      end
   endgenerate

   logic             open_q;
   logic             drop_q;
   logic             in_gate;
   logic             pop;
   logic             stray;
   logic             take;
   logic             drop_now;
   logic             deliver;
   logic             eop_end;
   logic [CNT_W-1:0] nbytes;

   assign in_ready = in_gate;
   assign pop      = in_valid && in_gate;
   assign stray    = !open_q && !in_sop;
   assign take     = pop && !stray;
   assign drop_now = open_q ? drop_q : in_err;
   assign deliver  = take && !drop_now;
   assign eop_end  = take && in_eop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         drop_q <= 1'b0;
      end else if (take) begin
         if (in_eop) begin
            open_q <= 1'b0;
            drop_q <= 1'b0;
         end else if (!open_q) begin
            open_q <= 1'b1;
            drop_q <= in_err;
         end
      end
   end

   prd_word_len #(.SIZE_W(SIZE_W), .CNT_W(CNT_W)) u_len (
      .is_last   (in_eop),
      .tail_size (in_size),
      .nbytes    (nbytes)
   );

   prd_req_ctl #(.BUDGET_W(BUDGET_W), .CNT_W(CNT_W)) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_mode   (rd_mode_e'(req_mode)),
      .req_budget (req_budget),
      .pkt_open   (open_q),
      .deliver    (deliver),
      .nbytes     (nbytes),
      .eop_end    (eop_end),
      .req_ready  (req_ready),
      .in_gate    (in_gate),
      .done       (done),
      .deficit    (deficit)
   );

   prd_drop_ctr #(.W(DROP_W), .SATURATE(DROP_SAT)) u_drop (
      .clk   (clk),
      .rst_n (rst_n),
      .bump  (eop_end && drop_now),
      .count (drop_count)
   );

   assign out_valid = deliver;
   assign out_data  = in_data;
   assign out_first = !open_q;
   assign out_last  = in_eop;
   assign out_bytes = nbytes;
endmodule

// File: rtl/prd_readout_chk.sv
module prd_readout_chk #(
   parameter int CNT_W  = 5,
   parameter int DROP_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              in_valid,
   input logic              in_ready,
   input logic              in_sop,
   input logic              in_err,
   input logic              open_q,
   input logic              out_valid,
   input logic              out_last,
   input logic [CNT_W-1:0]  out_bytes,
   input logic              done,
   input logic [DROP_W-1:0] drop_count
);
   localparam int FULL = 1 << (CNT_W - 1);

   AST_IDLE_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !in_ready); // R2
   AST_OUT_NEEDS_POP: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (in_valid && in_ready)); // R3
   AST_FULL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_last) |-> (out_bytes == CNT_W'(FULL))); // R4
   AST_TAIL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_last) |-> (out_bytes != '0 && out_bytes <= CNT_W'(FULL))); // R4
   AST_ERR_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !open_q && in_sop && in_err) |-> !out_valid); // R5
   AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(drop_count) |-> (drop_count == DROP_W'($past(drop_count) + 1'b1))); // R5
   AST_STRAY_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !open_q && !in_sop) |-> !out_valid); // R6
   AST_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_ready) |-> done); // R8
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
endmodule

bind prd_readout prd_readout_chk #(.CNT_W(SIZE_W + 1), .DROP_W(DROP_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .in_sop     (in_sop),
   .in_err     (in_err),
   .open_q     (open_q),
   .out_valid  (out_valid),
   .out_last   (out_last),
   .out_bytes  (out_bytes),
   .done       (done),
   .drop_count (drop_count)
);

// File: tb/sim_prd_readout.sv
`timescale 1ns/1ps
module sim_prd_readout;
   localparam int CLK_PERIOD = 10;
   localparam int DATA_W     = 128;
   localparam int SIZE_W     = 4;
   localparam int BUDGET_W   = 16;
   localparam int DROP_W     = 8;
   localparam int LIMIT      = 20000;

   logic                clk = 1'b0;
   logic                rst_n;
   logic                req_valid, req_ready, req_mode;
   logic [BUDGET_W-1:0] req_budget;
   logic                in_valid, in_ready, in_sop, in_eop, in_err;
   logic [DATA_W-1:0]   in_data;
   logic [SIZE_W-1:0]   in_size;
   logic                out_valid, out_first, out_last, done;
   logic [DATA_W-1:0]   out_data;
   logic [SIZE_W:0]     out_bytes;
   logic [BUDGET_W+1:0] deficit;
   logic [DROP_W-1:0]   drop_count;

   always #(CLK_PERIOD/2) clk = ~clk;

   prd_readout #(.DATA_W(DATA_W), .SIZE_W(SIZE_W), .BUDGET_W(BUDGET_W), .DROP_W(DROP_W)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_mode(req_mode), .req_budget(req_budget), .in_valid(in_valid),
      .in_ready(in_ready), .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
      .in_err(in_err), .in_size(in_size), .out_valid(out_valid), .out_data(out_data),
      .out_first(out_first), .out_last(out_last), .out_bytes(out_bytes),
      .done(done), .deficit(deficit), .drop_count(drop_count));

   int total = 0;
   int bad   = 0;

   // stimulus queues
   logic [DATA_W-1:0] dq[$];
   logic [6:0]        fq[$];   // {sop, eop, err, size}
   logic [16:0]       rq[$];   // {mode, budget}

   // reference model state
   bit m_busy, m_mode, m_open, m_drop, m_done, prev_done;
   int m_budget, m_acc, m_def, m_drops;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic add_pkt(input int nw, input int sz, input bit err1, input bit errmid, input int tag);
      for (int i = 0; i < nw; i++) begin
         dq.push_back({4{32'(tag * 16 + i)}});
         fq.push_back({(i == 0), (i == nw - 1), ((i == 0) ? err1 : (errmid && i == 1)), 4'(sz)});
      end
   endtask

   task automatic add_stray(input int tag);
      dq.push_back({4{32'(tag)}});
      fq.push_back({1'b0, 1'b0, 1'b0, 4'd0});
   endtask

   initial begin
      bit stop_c, hs, stray, dropw, deliv;
      int nb, cyc, settle;
      rst_n = 1'b0; req_valid = 0; req_mode = 0; req_budget = '0;
      in_valid = 0; in_data = '0; in_sop = 0; in_eop = 0; in_err = 0; in_size = '0;
      m_busy = 0; m_mode = 0; m_open = 0; m_drop = 0; m_done = 0; prev_done = 0;
      m_budget = 0; m_acc = 0; m_def = 0; m_drops = 0;

      // R7: packet mode, good packet of 3 words, tail 5 bytes
      rq.push_back({1'b0, 16'd0});  add_pkt(3, 5, 0, 0, 1);
      // R5: packet mode ending on a dropped packet
      rq.push_back({1'b0, 16'd0});  add_pkt(2, 7, 1, 0, 2);
      // R6: stray word, then single-word packet with tail code 0 (16 bytes)
      rq.push_back({1'b0, 16'd0});  add_stray(99); add_pkt(1, 0, 0, 0, 3);
      // R8: budget 40 -> 19 bytes, then 40 bytes, overshoot -19
      rq.push_back({1'b1, 16'd40}); add_pkt(2, 3, 0, 0, 4); add_pkt(3, 8, 0, 0, 5);
      // R8: zero budget ends without a pop
      rq.push_back({1'b1, 16'd0});
      // R8: dropped packet adds nothing, then exactly 32 bytes, deficit 0
      rq.push_back({1'b1, 16'd32}); add_pkt(1, 2, 1, 0, 6); add_pkt(2, 0, 0, 0, 7);
      // R5: error marker on a middle word only is ignored
      rq.push_back({1'b0, 16'd0});  add_pkt(3, 15, 0, 1, 8);

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R10 reset state
      chk(req_ready == 1'b1, "R10 req_ready", req_ready, 1);
      chk(in_ready == 1'b0,  "R10 in_ready", in_ready, 0);
      chk(out_valid == 1'b0, "R10 out_valid", out_valid, 0);
      chk(done == 1'b0,      "R10 done", done, 0);
      chk(deficit == '0,     "R10 deficit", int'(deficit), 0);
      chk(drop_count == '0,  "R10 drop_count", int'(drop_count), 0);

      cyc = 0; settle = 0;
      while (settle < 4 && cyc < LIMIT) begin
         @(negedge clk);
         req_valid = (rq.size() > 0);
         {req_mode, req_budget} = (rq.size() > 0) ? rq[0] : 17'd0;
         in_valid = (dq.size() > 0) && (cyc % 7 != 4);
         in_data  = (dq.size() > 0) ? dq[0] : '0;
         {in_sop, in_eop, in_err, in_size} = (fq.size() > 0) ? fq[0] : 7'd0;
         #1;
         stop_c = m_busy && m_mode && !m_open && (m_acc >= m_budget);
         hs     = in_valid && m_busy && !stop_c;
         stray  = !m_open && !in_sop;
         dropw  = m_open ? m_drop : in_err;
         deliv  = hs && !stray && !dropw;
         nb     = (!in_eop || in_size == 0) ? 16 : int'(in_size);

         chk(req_ready == !m_busy, "R1 req_ready", req_ready, !m_busy);
         chk(in_ready == (m_busy && !stop_c), "R2 in_ready", in_ready, m_busy && !stop_c);
         chk(out_valid == deliv, (hs && stray) ? "R6 out_valid" : (hs && dropw) ? "R5 out_valid" : "R3 out_valid",
             out_valid, deliv);
         if (deliv) begin
            chk(out_data == in_data, "R3 out_data", int'(out_data[31:0]), int'(in_data[31:0]));
            chk(out_first == !m_open, "R3 out_first", out_first, !m_open);
            chk(out_last == in_eop, "R3 out_last", out_last, in_eop);
            chk(int'(out_bytes) == nb, "R4 out_bytes", int'(out_bytes), nb);
         end
         chk(done == m_done, m_mode ? "R8 done" : "R7 done", done, m_done);
         chk(!(prev_done && done), "R9 done pulse", done, 0);
         chk(int'($signed(deficit)) == m_def, "R8 deficit", int'($signed(deficit)), m_def);
         chk(int'(drop_count) == (m_drops % 256), "R5 drop_count", int'(drop_count), m_drops % 256);
         prev_done = done;

         @(posedge clk);
         m_done = 0;
         if (!m_busy) begin
            if (req_valid) begin
               m_busy = 1; m_mode = req_mode; m_budget = int'(req_budget); m_acc = 0;
               void'(rq.pop_front());
            end
         end else if (stop_c) begin
            m_busy = 0; m_done = 1; m_def = m_budget - m_acc;
         end else if (hs) begin
            void'(dq.pop_front()); void'(fq.pop_front());
            if (!stray) begin
               if (deliv) m_acc += nb;
               if (in_eop) begin
                  m_open = 0; m_drop = 0;
                  if (dropw) m_drops++;
                  if (!m_mode) begin m_busy = 0; m_done = 1; end
               end else if (!m_open) begin
                  m_open = 1; m_drop = in_err;
               end
            end
         end
         cyc++;
         if (rq.size() == 0 && dq.size() == 0 && !m_busy) settle++;
      end

      if (cyc >= LIMIT) begin
         total++; bad++;
         $display("FAIL watchdog expired after %0d cycles", cyc);
      end
      chk(m_drops == 2, "R5 total drops", m_drops, 2);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule